// File: doc/BRIEF.md
# Store-Right Byte-Lane Write Unit

This unit carries out the "store right" half of an unaligned 32-bit store, issued as an extended (two-halfword) compact instruction. It checks that the 32-bit instruction word is this operation. It reads a base register and a source register through a combinational register-file port and adds the sign-extended 9-bit offset to the base. From the low two bits of that sum and the core's endianness it picks a starting byte lane. It then writes the low 1 to 4 bytes of the source register into that lane and every lane above it in the aligned word.

The result is presented on a registered write-request port with a byte enable per lane and a valid/ready handshake. While a request is waiting for the memory, the unit refuses new instructions. An instruction word that does not decode as this operation produces a one-cycle "not mine" pulse and no write.

Top module: `swr_lane_unit`

## Requirements
- R1: The instruction is accepted as this operation only when bits [31:27]=11110, [26:25]=00, [20:19]=10, [15:11]=11010 and [7:5]=111. The offset is {bits[24:21], bits[4:0]}, the base code is bits[18:16] and the source code is bits[10:8].
- R2: A 3-bit register code c selects register 16 when c=0, register 17 when c=1, and register c otherwise. The selected numbers appear on the base and source read-index ports.
- R3: The effective address is the base register value plus the 9-bit offset, sign-extended to 32 bits. The request address is that sum with bits [1:0] forced to zero.
- R4: The lane index is the effective address bits [1:0], inverted in both bits when the big-endian input is 1 and unchanged when it is 0.
- R5: The write data is the source register shifted left by 8 times the lane index, with zero bytes in the lanes below the lane index.
- R6: Byte enable bit k is 1 exactly when k is greater than or equal to the lane index. Lane index 0 therefore gives 1111 and lane index 3 gives 1000, so 4 minus the lane index bytes are written.
- R7: An accepted word that fails the R1 match raises not_mine for exactly the next cycle and starts no write request.
- R8: A write request appears in the cycle after acceptance. Address, data and enables stay unchanged until the cycle in which mem_ready is high. in_ready is low while a request is outstanding, and in_valid is ignored during that time.
- R9: A synchronous active-high reset drops the pending request and not_mine, and clears address, data and enables to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| big_endian | input | 1 | 1 selects big-endian lane numbering |
| in_valid | input | 1 | Instruction word offered |
| in_ready | output | 1 | Unit can take an instruction this cycle |
| in_insn | input | 32 | Extended instruction word, prefix halfword in bits [31:16] |
| rf_base_idx | output | 5 | Register-file read index for the base register |
| rf_base_data | input | 32 | Base register value (combinational read) |
| rf_src_idx | output | 5 | Register-file read index for the source register |
| rf_src_data | input | 32 | Source register value (combinational read) |
| not_mine | output | 1 | One-cycle pulse: accepted word was not this operation |
| mem_valid | output | 1 | Write request pending |
| mem_ready | input | 1 | Memory takes the pending request |
| mem_addr | output | 32 | Word-aligned write address |
| mem_wdata | output | 32 | Lane-shifted write data |
| mem_be | output | 4 | Byte enables, bit k for bits [8k+7:8k] |

## Verification
The properties assume that the register file answers within the same cycle as the index it is given. They also assume that big_endian and the instruction word are only sampled in the accept cycle, and that the memory side raises mem_ready only as a single-cycle take. The stimulus changes inputs only at falling edges. It holds mem_ready low for zero to three cycles before raising it for one cycle. It offers in_valid while busy only to show that the word is dropped. The bench's register file is a pure function of the read index, so every read is stable for a whole cycle.

// File: rtl/swr_pkg.sv
package swr_pkg;
  localparam int unsigned XLEN  = 32;
  localparam int unsigned NBYTE = XLEN / 8;
  localparam int unsigned LANEW = $clog2(NBYTE);
  localparam int unsigned OFFW  = 9;
  localparam int unsigned RIDXW = 5;
  localparam int unsigned RCODW = 3;

  typedef struct packed {
    logic [XLEN-1:0]  addr;
    logic [XLEN-1:0]  data;
    logic [NBYTE-1:0] be;
  } wreq_t;

  // compact register code to architectural register number
  function automatic logic [RIDXW-1:0] map_reg(input logic [RCODW-1:0] code);
    if (code < 3'd2) return {4'b1000, code[0]};
    return {2'b00, code};
  endfunction

  // starting byte lane from address offset and byte order
  function automatic logic [LANEW-1:0] lane_of(input logic [LANEW-1:0] lo,
                                               input logic big);
    return lo ^ {LANEW{big}};
  endfunction

  function automatic logic [XLEN-1:0] sext_off(input logic [OFFW-1:0] off);
    return {{(XLEN-OFFW){off[OFFW-1]}}, off};
  endfunction
endpackage

// File: rtl/swr_decode.sv
module swr_decode
  import swr_pkg::*;
(
  input  logic [31:0]       insn,
  output logic              match,
  output logic [OFFW-1:0]   off,
  output logic [RIDXW-1:0]  base_idx,
  output logic [RIDXW-1:0]  src_idx
);
  logic pfx_ok, base_ok;

  always_comb begin
    pfx_ok   = (insn[31:27] == 5'b11110) && (insn[26:25] == 2'b00) &&
               (insn[20:19] == 2'b10);
    base_ok  = (insn[15:11] == 5'b11010) && (insn[7:5] == 3'b111);
    match    = pfx_ok && base_ok;
    off      = {insn[24:21], insn[4:0]};
    base_idx = map_reg(insn[18:16]);
    src_idx  = map_reg(insn[10:8]);
  end
endmodule

// File: rtl/swr_lane.sv
module swr_lane
  import swr_pkg::*;
(
  input  logic [XLEN-1:0]  base,
  input  logic [XLEN-1:0]  src,
  input  logic [OFFW-1:0]  off,
  input  logic             big,
  output wreq_t            req
);
  logic [XLEN-1:0]  ea;
  logic [LANEW-1:0] lane;

  always_comb begin
    ea   = base + sext_off(off);
    lane = lane_of(ea[LANEW-1:0], big);
  end

  assign req.addr = {ea[XLEN-1:LANEW], {LANEW{1'b0}}};
  assign req.data = src << {lane, 3'b000};

  for (genvar k = 0; k < NBYTE; k++) begin : g_be
    assign req.be[k] = (k >= int'(lane));
  end
endmodule

// File: rtl/swr_req_hold.sv
module swr_req_hold
  import swr_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  load,
  input  logic  drain,
  input  wreq_t req_in,
  output logic  valid,
  output wreq_t req_out
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid   <= 1'b0;
      req_out <= '0;
    end else if (load) begin
      valid   <= 1'b1;
      req_out <= req_in;
    end else if (drain) begin
      valid   <= 1'b0;
    end
  end
endmodule

// File: rtl/swr_lane_unit.sv
module swr_lane_unit
  import swr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             big_endian,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [31:0]      in_insn,
  output logic [RIDXW-1:0] rf_base_idx,
  input  logic [XLEN-1:0]  rf_base_data,
  output logic [RIDXW-1:0] rf_src_idx,
  input  logic [XLEN-1:0]  rf_src_data,
  output logic             not_mine,
  output logic             mem_valid,
  input  logic             mem_ready,
  output logic [XLEN-1:0]  mem_addr,
  output logic [XLEN-1:0]  mem_wdata,
  output logic [NBYTE-1:0] mem_be
);
  logic            dec_match;
  logic [OFFW-1:0] dec_off;
  wreq_t           lane_req, held_req;

  // named events for the checker
  logic accept_w, issue_w, reject_w, drain_w;

  swr_decode u_dec (
    .insn     (in_insn),
    .match    (dec_match),
    .off      (dec_off),
    .base_idx (rf_base_idx),
    .src_idx  (rf_src_idx)
  );

  swr_lane u_lane (
    .base (rf_base_data),
    .src  (rf_src_data),
    .off  (dec_off),
    .big  (big_endian),
    .req  (lane_req)
  );

  assign in_ready = !mem_valid;
  assign accept_w = in_valid && in_ready;
  assign issue_w  = accept_w && dec_match;
  assign reject_w = accept_w && !dec_match;
  assign drain_w  = mem_valid && mem_ready;

  swr_req_hold u_hold (
    .clk     (clk),
    .rst     (rst),
    .load    (issue_w),
    .drain   (drain_w),
    .req_in  (lane_req),
    .valid   (mem_valid),
    .req_out (held_req)
  );

  always_ff @(posedge clk) begin
    if (rst) not_mine <= 1'b0;
    else     not_mine <= reject_w;
  end

  assign mem_addr  = held_req.addr;
  assign mem_wdata = held_req.data;
  assign mem_be    = held_req.be;
endmodule

// File: rtl/swr_lane_unit_chk.sv
module swr_lane_unit_chk
  import swr_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             in_ready,
  input logic             not_mine,
  input logic             mem_valid,
  input logic             mem_ready,
  input logic [XLEN-1:0]  mem_addr,
  input logic [XLEN-1:0]  mem_wdata,
  input logic [NBYTE-1:0] mem_be,
  input logic             issue_w,
  input logic             reject_w
);
  logic [XLEN-1:0] be_mask;
  for (genvar k = 0; k < NBYTE; k++) begin : g_mask
    assign be_mask[8*k +: 8] = {8{mem_be[k]}};
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) &&
    $stable(mem_wdata) && $stable(mem_be)); // R8
  AST_ISSUE_RAISES: assert property (@(posedge clk) disable iff (rst)
    issue_w |=> mem_valid && !in_ready); // R8
  AST_REJECT_PULSE: assert property (@(posedge clk) disable iff (rst)
    reject_w |=> not_mine && !mem_valid); // R7
  AST_BE_SHAPE: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> mem_be[NBYTE-1] &&
    (((mem_be | (mem_be << 1)) & {NBYTE{1'b1}}) == mem_be)); // R6
  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> mem_addr[LANEW-1:0] == '0); // R3
  AST_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> (mem_wdata & ~be_mask) == '0); // R5
  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !mem_valid && !not_mine && mem_be == '0); // R9
endmodule

bind swr_lane_unit swr_lane_unit_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_ready  (in_ready),
  .not_mine  (not_mine),
  .mem_valid (mem_valid),
  .mem_ready (mem_ready),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_be    (mem_be),
  .issue_w   (issue_w),
  .reject_w  (reject_w)
);

// File: tb/swr_lane_unit_test.sv
module swr_lane_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        big_endian = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_insn = '0;
  logic [4:0]  rf_base_idx, rf_src_idx;
  logic [31:0] rf_base_data, rf_src_data;
  logic        not_mine, mem_valid;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_addr, mem_wdata;
  logic [3:0]  mem_be;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  swr_lane_unit uut (
    .clk(clk), .rst(rst), .big_endian(big_endian),
    .in_valid(in_valid), .in_ready(in_ready), .in_insn(in_insn),
    .rf_base_idx(rf_base_idx), .rf_base_data(rf_base_data),
    .rf_src_idx(rf_src_idx), .rf_src_data(rf_src_data),
    .not_mine(not_mine), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be)
  );

  function automatic logic [31:0] rfv(input logic [4:0] i);
    return 32'hA1B2C3D4 + {3'b0, i, 3'b0, i, 3'b0, i, 3'b0, i};
  endfunction
  assign rf_base_data = rfv(rf_base_idx);
  assign rf_src_data  = rfv(rf_src_idx);

  function automatic logic [4:0] arch(input logic [2:0] c);
    case (c)
      3'd0:    return 5'd16;
      3'd1:    return 5'd17;
      default: return {2'b00, c};
    endcase
  endfunction

  // bad: 0 correct, 1 wrong selector, 2 wrong base major, 3 wrong middle field
  function automatic logic [31:0] mk(input logic [8:0] imm, input logic [2:0] rb,
                                     input logic [2:0] rx, input logic [1:0] bad);
    return {5'b11110, 2'b00, imm[8:5], (bad == 2'd3) ? 2'b11 : 2'b10, rb,
            (bad == 2'd2) ? 5'b11011 : 5'b11010, rx,
            (bad == 2'd1) ? 3'b110 : 3'b111, imm[4:0]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [8:0] imm, input logic [2:0] rb, input logic [2:0] rx,
                        input logic bem, input logic [1:0] bad, input int dly);
    logic [31:0] ea, src, e_data;
    logic [1:0]  ln;
    logic [3:0]  e_be;
    ea  = rfv(arch(rb)) + {{23{imm[8]}}, imm};
    src = rfv(arch(rx));
    ln  = bem ? (2'd3 - ea[1:0]) : ea[1:0];
    case (ln)
      2'd0: begin e_be = 4'b1111; e_data = src; end
      2'd1: begin e_be = 4'b1110; e_data = {src[23:0], 8'h00}; end
      2'd2: begin e_be = 4'b1100; e_data = {src[15:0], 16'h0000}; end
      default: begin e_be = 4'b1000; e_data = {src[7:0], 24'h000000}; end
    endcase
    @(negedge clk);
    in_insn = mk(imm, rb, rx, bad); big_endian = bem; in_valid = 1'b1;
    #1;
    chk("R2 base index", {27'b0, rf_base_idx}, {27'b0, arch(rb)});
    chk("R2 source index", {27'b0, rf_src_idx}, {27'b0, arch(rx)});
    @(negedge clk);
    in_valid = 1'b0;
    if (bad != 2'd0) begin
      chk("R7 not_mine raised", {31'b0, not_mine}, 32'd1);
      chk("R7 no write", {31'b0, mem_valid}, 32'd0);
      @(negedge clk);
      chk("R7 not_mine one cycle", {31'b0, not_mine}, 32'd0);
      chk("R7 still no write", {31'b0, mem_valid}, 32'd0);
      return;
    end
    chk("R1 request raised", {31'b0, mem_valid}, 32'd1);
    chk("R3 address", mem_addr, {ea[31:2], 2'b00});
    chk("R4 R5 data", mem_wdata, e_data);
    chk("R4 R6 enables", {28'b0, mem_be}, {28'b0, e_be});
    chk("R8 busy", {31'b0, in_ready}, 32'd0);
    for (int i = 0; i < dly; i++) begin
      @(negedge clk);
      chk("R8 held addr", mem_addr, {ea[31:2], 2'b00});
      chk("R8 held data", mem_wdata, e_data);
      chk("R8 held valid", {31'b0, mem_valid}, 32'd1);
    end
    mem_ready = 1'b1;
    @(negedge clk);
    mem_ready = 1'b0;
    chk("R8 drained", {31'b0, mem_valid}, 32'd0);
    chk("R8 ready again", {31'b0, in_ready}, 32'd1);
  endtask

  // {imm9, rb3, rx3, big1, bad2, dly2}
  localparam logic [19:0] VEC [12] = '{
    {9'h000, 3'd0, 3'd1, 1'b0, 2'd0, 2'd0},
    {9'h001, 3'd2, 3'd3, 1'b0, 2'd0, 2'd1},
    {9'h002, 3'd4, 3'd5, 1'b1, 2'd0, 2'd0},
    {9'h003, 3'd6, 3'd7, 1'b1, 2'd0, 2'd2},
    {9'h1FF, 3'd1, 3'd0, 1'b0, 2'd0, 2'd0},
    {9'h100, 3'd3, 3'd2, 1'b1, 2'd0, 2'd1},
    {9'h0FF, 3'd5, 3'd4, 1'b0, 2'd0, 2'd3},
    {9'h0A5, 3'd7, 3'd6, 1'b1, 2'd0, 2'd0},
    {9'h010, 3'd2, 3'd2, 1'b0, 2'd1, 2'd0},
    {9'h010, 3'd2, 3'd2, 1'b1, 2'd2, 2'd0},
    {9'h010, 3'd2, 3'd2, 1'b0, 2'd3, 2'd0},
    {9'h155, 3'd0, 3'd7, 1'b0, 2'd0, 2'd1}
  };

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    logic [31:0] a0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 reset valid", {31'b0, mem_valid}, 32'd0);
    chk("R9 reset not_mine", {31'b0, not_mine}, 32'd0);
    chk("R9 reset addr", mem_addr, 32'd0);
    chk("R9 reset data", mem_wdata, 32'd0);
    chk("R9 reset enables", {28'b0, mem_be}, 32'd0);
    chk("R9 ready after reset", {31'b0, in_ready}, 32'd1);

    foreach (VEC[i])
      run_op(VEC[i][19:11], VEC[i][10:8], VEC[i][7:5], VEC[i][4], VEC[i][3:2],
             int'(VEC[i][1:0]));

    // every lane in both byte orders (R4, R6)
    for (int m = 0; m < 2; m++)
      for (int o = 0; o < 4; o++)
        run_op(9'(o), 3'd2, 3'd5, m[0], 2'd0, 0);

    // R8: word offered while busy is dropped
    @(negedge clk);
    in_insn = mk(9'h004, 3'd3, 3'd4, 2'd0); big_endian = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    a0 = mem_addr;
    in_insn = mk(9'h0F0, 3'd6, 3'd1, 2'd0);
    @(negedge clk);
    chk("R8 busy word ignored addr", mem_addr, a0);
    in_valid = 1'b0; mem_ready = 1'b1;
    @(negedge clk);
    mem_ready = 1'b0;
    @(negedge clk);
    chk("R8 busy word never issued", {31'b0, mem_valid}, 32'd0);
    chk("R8 busy word no not_mine", {31'b0, not_mine}, 32'd0);

    // R9: reset while a request is pending
    in_insn = mk(9'h007, 3'd4, 3'd6, 2'd0); in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9 pending before reset", {31'b0, mem_valid}, 32'd1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R9 reset drops request", {31'b0, mem_valid}, 32'd0);
    chk("R9 reset clears data", mem_wdata, 32'd0);
    chk("R9 ready after mid reset", {31'b0, in_ready}, 32'd1);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule